// File: doc/BRIEF.md
# Conversion and Calibration Sequencer

This block sits behind the modulator and decimation filter of a delta-sigma converter. It keeps time for the conversion periods and produces the active-low data-ready strobe that tells a host when a fresh 24-bit result is waiting. Filter results arrive as a word with a one-cycle valid pulse. The sequencer moves each accepted word into the output register with a short data-ready handshake. When the host reads the word, it clears data-ready.

Decoded calibration requests start a two-period calibration. While it runs, normal results are held off. When it ends, the offset and/or full-scale calibration registers are loaded from stubbed measurement inputs, data-ready drops to mark completion, and the first filter word after that is thrown away as corrupt.

A sync request pulses a filter reset and holds the modulator until the next serial clock edge. The period timer then restarts from zero.

Top module: `conv_cal_seq`

## Requirements
- R1: While not held by a sync, `period_tick` is high for one clock in every `DATA_PERIOD` clocks.
- R2: A `filt_valid` pulse that is accepted drives `drdy_n` high on the next clock edge. On the edge after that, the word appears on `dout_word` and `drdy_n` goes low. `dout_word` never changes while `drdy_n` was low in the cycle before.
- R3: A `rd_done` pulse while no update is pending returns `drdy_n` high.
- R4: Bit 7 of `acr_rd` always equals `drdy_n`, and bits 6:0 equal `acr_cfg`.
- R5: An accepted calibration raises `cal_busy` on the next edge. The calibration completes on the edge that consumes the second `period_tick` seen while busy. On that edge `cal_busy` falls and `drdy_n` goes low.
- R6: `cal_kind` encodings are 0 combined self, 1 self offset, 2 self gain, 3 system offset and 4 system gain. Values 5 to 7 are ignored. Offset kinds (0, 1, 3) load `ofs_reg` from `meas_ofs` at completion. Gain kinds (0, 2, 4) load `fs_reg` from `meas_fs`. Neither register changes at any other time.
- R7: Kinds 0 and 2 require `gain_code` 0, which means unity gain. Otherwise they do not start and set `cal_err`. `cal_err` stays set until reset. Kind 1 starts at any gain.
- R8: A calibration request that arrives while `cal_busy` is high is ignored. The running calibration keeps its kind, and `cal_busy` stays high until it completes.
- R9: Filter words that arrive while `cal_busy` is high are dropped. The first word after completion is dropped, and the second is delivered.
- R10: `sync_req` gives a one-cycle `filt_rst` pulse on the next edge and sets `mod_hold`. No tick occurs while `mod_hold` is high. `sclk_edge` clears `mod_hold`. The first tick is then seen after exactly `DATA_PERIOD` rising edges, counting the edge that samples `sclk_edge`.
- R11: After reset, `drdy_n` is high. `cal_busy`, `cal_err`, `mod_hold`, `filt_rst`, `ofs_reg`, `fs_reg` and `dout_word` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cal_req | input | 1 | Decoded calibration command pulse |
| cal_kind | input | 3 | Calibration kind (R6 encoding) |
| gain_code | input | 3 | Current gain setting, 0 = unity |
| meas_ofs | input | 24 | Stubbed offset measurement |
| meas_fs | input | 24 | Stubbed full-scale measurement |
| filt_valid | input | 1 | Filter result valid pulse |
| filt_data | input | 24 | Filter result word |
| rd_done | input | 1 | Host read of the output register finished |
| sync_req | input | 1 | Last serial clock edge of a sync command |
| sclk_edge | input | 1 | Serial clock edge detected |
| acr_cfg | input | 7 | Configuration bits of the status/config register |
| period_tick | output | 1 | Conversion period tick |
| filt_rst | output | 1 | Filter reset pulse |
| mod_hold | output | 1 | Modulator held in reset |
| drdy_n | output | 1 | Active-low data ready |
| dout_word | output | 24 | Output data register |
| cal_busy | output | 1 | Calibration running |
| cal_err | output | 1 | Sticky gain-rule violation |
| ofs_reg | output | 24 | Offset calibration register |
| fs_reg | output | 24 | Full-scale calibration register |
| acr_rd | output | 8 | Register read view, bit 7 = data ready |

## Verification
Some properties are checked on every cycle. These are:
- no tick while the modulator is held;
- the output register changes only after a cycle with data-ready high;
- calibration completion coincides with data-ready low;
- the error flag is sticky;
- a busy calibration cannot be displaced;
- an offset-only calibration leaves the full-scale register alone;
- the mirrored status bit.

Other behaviour depends on counted windows and sequences, so only the directed scenarios show it. This covers:
- exact tick spacing and the restart distance after a sync;
- completion after two ticks;
- which registers each calibration kind loads;
- dropping the first word after calibration;
- the effect of a read.

// File: rtl/conv_cal_seq_pkg.sv
// Package: shared types for the conversion and calibration sequencer.
package conv_cal_seq_pkg;

    // Calibration kinds as decoded from the command stream.
    typedef enum logic [2:0] {
        CAL_SELF_BOTH = 3'd0,
        CAL_SELF_OFS  = 3'd1,
        CAL_SELF_GAIN = 3'd2,
        CAL_SYS_OFS   = 3'd3,
        CAL_SYS_GAIN  = 3'd4
    } cal_kind_e;

    // True for kinds that load the offset register.
    function automatic logic kind_hits_ofs(input logic [2:0] k);
        return (k == CAL_SELF_BOTH) || (k == CAL_SELF_OFS) || (k == CAL_SYS_OFS);
    endfunction

    // True for kinds that load the full-scale register.
    function automatic logic kind_hits_fs(input logic [2:0] k);
        return (k == CAL_SELF_BOTH) || (k == CAL_SELF_GAIN) || (k == CAL_SYS_GAIN);
    endfunction

    // True for kinds that may only run at unity gain.
    function automatic logic kind_needs_unity(input logic [2:0] k);
        return (k == CAL_SELF_BOTH) || (k == CAL_SELF_GAIN);
    endfunction

endpackage

// File: rtl/seq_period_gen.sv
// Module: seq_period_gen
// Counts conversion periods and raises a tick on the last cycle of each one.
// It also handles resynchronisation: a sync request pulses the filter reset
// and holds the counter at zero until a serial clock edge releases it.
// Assumes: DATA_PERIOD >= 2, and sync_req/sclk_edge are single-cycle pulses.
module seq_period_gen #(
    parameter int DATA_PERIOD = 8,
    localparam int CW = (DATA_PERIOD > 1) ? $clog2(DATA_PERIOD) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_req,
    input  logic sclk_edge,
    output logic tick,
    output logic filt_rst,
    output logic mod_hold
);
    localparam logic [CW-1:0] LAST = CW'(DATA_PERIOD - 1);

    logic [CW-1:0] cnt;

    // Period counter, parked at zero during a sync or while the modulator is held.
    always_ff @(posedge clk) begin
        if (!rst_n)                  cnt <= '0;
        else if (sync_req || mod_hold) cnt <= '0;
        else if (cnt == LAST)        cnt <= '0;
        else                         cnt <= cnt + 1'b1;
    end

    // Hold flag and one-cycle filter reset for the sync sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mod_hold <= 1'b0;
            filt_rst <= 1'b0;
        end else begin
            filt_rst <= sync_req;
            if (sync_req)                   mod_hold <= 1'b1;
            else if (mod_hold && sclk_edge) mod_hold <= 1'b0;
        end
    end

    assign tick = (cnt == LAST);

    // R10: the held modulator never produces a period tick.
    assert_no_tick_in_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mod_hold |-> !tick);

    // R10: a sync request is followed by a filter reset pulse and a hold.
    assert_sync_resets_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sync_req |=> (filt_rst && mod_hold));
endmodule

// File: rtl/seq_cal_ctrl.sv
// Module: seq_cal_ctrl
// Runs one calibration at a time. An accepted request lasts until the second
// period tick seen while busy. At completion the offset and/or full-scale
// registers are loaded from the measurement inputs.
// Assumes: cal_req is a one-cycle pulse; measurements are stable at completion.
module seq_cal_ctrl
    import conv_cal_seq_pkg::*;
#(
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cal_req,
    input  logic [2:0]        cal_kind,
    input  logic [2:0]        gain_code,
    input  logic              tick,
    input  logic [WORD_W-1:0] meas_ofs,
    input  logic [WORD_W-1:0] meas_fs,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [WORD_W-1:0] ofs_q,
    output logic [WORD_W-1:0] fs_q
);
    logic       half_seen;
    logic [2:0] kind_q;
    logic       kind_known;
    logic       gain_bad;
    logic       start;

    assign kind_known = (cal_kind <= 3'(CAL_SYS_GAIN));
    assign gain_bad   = kind_needs_unity(cal_kind) && (gain_code != 3'd0);
    assign start      = cal_req && !busy && kind_known && !gain_bad;
    assign done       = busy && tick && half_seen;

    // Calibration state: start, first-period mark, completion and register loads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            half_seen <= 1'b0;
            kind_q    <= 3'd0;
            ofs_q     <= '0;
            fs_q      <= '0;
        end else if (done) begin
            busy      <= 1'b0;
            half_seen <= 1'b0;
            if (kind_hits_ofs(kind_q)) ofs_q <= meas_ofs;
            if (kind_hits_fs(kind_q))  fs_q  <= meas_fs;
        end else if (busy && tick) begin
            half_seen <= 1'b1;
        end else if (start) begin
            busy      <= 1'b1;
            half_seen <= 1'b0;
            kind_q    <= cal_kind;
        end
    end

    // Sticky flag for requests refused by the unity-gain rule.
    always_ff @(posedge clk) begin
        if (!rst_n)                                       err <= 1'b0;
        else if (cal_req && !busy && kind_known && gain_bad) err <= 1'b1;
    end

    // R7: once raised, the error flag never clears without reset.
    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    // R8: a request during a running calibration neither ends it nor changes its kind.
    assert_busy_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cal_req && !tick) |=> (busy && $stable(kind_q)));

    // R6: an offset-only completion leaves the full-scale register untouched.
    assert_ofs_only_keeps_fs_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !kind_hits_fs(kind_q)) |=> $stable(fs_q));
endmodule

// File: rtl/seq_data_gate.sv
// Module: seq_data_gate
// Owns the output register and the active-low data-ready strobe. Each accepted
// filter word first raises data-ready for one cycle, then lands in the
// register with data-ready low. Words are dropped while calibrating, and the
// first word after a calibration is dropped as well.
// Assumes: filt_valid pulses are spaced by more than two cycles.
module seq_data_gate #(
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              filt_valid,
    input  logic [WORD_W-1:0] filt_data,
    input  logic              rd_done,
    input  logic              cal_busy,
    input  logic              cal_done,
    output logic              drdy_n,
    output logic [WORD_W-1:0] dout
);
    logic              pend;
    logic              discard;
    logic [WORD_W-1:0] pend_data;

    // Data-ready handshake, pending update and post-calibration discard.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drdy_n    <= 1'b1;
            dout      <= '0;
            pend      <= 1'b0;
            discard   <= 1'b0;
            pend_data <= '0;
        end else if (cal_done) begin
            drdy_n  <= 1'b0;
            discard <= 1'b1;
            pend    <= 1'b0;
        end else if (pend) begin
            dout   <= pend_data;
            drdy_n <= 1'b0;
            pend   <= 1'b0;
        end else if (filt_valid && !cal_busy) begin
            if (discard) begin
                discard <= 1'b0;
            end else begin
                pend      <= 1'b1;
                pend_data <= filt_data;
                drdy_n    <= 1'b1;
            end
        end else if (rd_done) begin
            drdy_n <= 1'b1;
        end
    end

    // R2: the output register only changes after a cycle with data-ready high.
    assert_update_after_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dout) |-> $past(drdy_n));
endmodule

// File: rtl/conv_cal_seq.sv
// Module: conv_cal_seq (top)
// Wires the period generator, calibration controller and data gate together,
// and builds the register read view with data-ready in bit 7.
// Assumes: all request inputs are synchronous single-cycle pulses.
module conv_cal_seq
    import conv_cal_seq_pkg::*;
#(
    parameter int DATA_PERIOD = 8,
    parameter int WORD_W      = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cal_req,
    input  logic [2:0]        cal_kind,
    input  logic [2:0]        gain_code,
    input  logic [WORD_W-1:0] meas_ofs,
    input  logic [WORD_W-1:0] meas_fs,
    input  logic              filt_valid,
    input  logic [WORD_W-1:0] filt_data,
    input  logic              rd_done,
    input  logic              sync_req,
    input  logic              sclk_edge,
    input  logic [6:0]        acr_cfg,
    output logic              period_tick,
    output logic              filt_rst,
    output logic              mod_hold,
    output logic              drdy_n,
    output logic [WORD_W-1:0] dout_word,
    output logic              cal_busy,
    output logic              cal_err,
    output logic [WORD_W-1:0] ofs_reg,
    output logic [WORD_W-1:0] fs_reg,
    output logic [7:0]        acr_rd
);
    logic cal_done;

    seq_period_gen #(.DATA_PERIOD(DATA_PERIOD)) u_period (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_req (sync_req),
        .sclk_edge(sclk_edge),
        .tick     (period_tick),
        .filt_rst (filt_rst),
        .mod_hold (mod_hold)
    );

    seq_cal_ctrl #(.WORD_W(WORD_W)) u_cal (
        .clk      (clk),
        .rst_n    (rst_n),
        .cal_req  (cal_req),
        .cal_kind (cal_kind),
        .gain_code(gain_code),
        .tick     (period_tick),
        .meas_ofs (meas_ofs),
        .meas_fs  (meas_fs),
        .busy     (cal_busy),
        .done     (cal_done),
        .err      (cal_err),
        .ofs_q    (ofs_reg),
        .fs_q     (fs_reg)
    );

    seq_data_gate #(.WORD_W(WORD_W)) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .filt_valid(filt_valid),
        .filt_data (filt_data),
        .rd_done   (rd_done),
        .cal_busy  (cal_busy),
        .cal_done  (cal_done),
        .drdy_n    (drdy_n),
        .dout      (dout_word)
    );

    assign acr_rd = {drdy_n, acr_cfg};

    // R5: calibration end and the completion strobe happen on the same edge.
    assert_cal_end_drdy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cal_busy) |-> !drdy_n);

    // R4: the register view always carries the live data-ready level.
    assert_mirror_R4: assert property (@(posedge clk) disable iff (!rst_n)
        acr_rd[7] == drdy_n);
endmodule

// File: tb/conv_cal_seq_test.sv
module conv_cal_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int DP = 8;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cal_req, filt_valid, rd_done, sync_req, sclk_edge;
    logic [2:0]  cal_kind, gain_code;
    logic [23:0] meas_ofs, meas_fs, filt_data;
    logic [6:0]  acr_cfg;
    logic        period_tick, filt_rst, mod_hold, drdy_n, cal_busy, cal_err;
    logic [23:0] dout_word, ofs_reg, fs_reg;
    logic [7:0]  acr_rd;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    conv_cal_seq #(.DATA_PERIOD(DP), .WORD_W(24)) uut (
        .clk(clk), .rst_n(rst_n), .cal_req(cal_req), .cal_kind(cal_kind),
        .gain_code(gain_code), .meas_ofs(meas_ofs), .meas_fs(meas_fs),
        .filt_valid(filt_valid), .filt_data(filt_data), .rd_done(rd_done),
        .sync_req(sync_req), .sclk_edge(sclk_edge), .acr_cfg(acr_cfg),
        .period_tick(period_tick), .filt_rst(filt_rst), .mod_hold(mod_hold),
        .drdy_n(drdy_n), .dout_word(dout_word), .cal_busy(cal_busy),
        .cal_err(cal_err), .ofs_reg(ofs_reg), .fs_reg(fs_reg), .acr_rd(acr_rd)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Starts a calibration and returns the number of ticks seen while busy.
    task automatic run_cal(input logic [2:0] kind, output int ticks);
        int guard;
        cal_kind = kind; cal_req = 1'b1;
        @(negedge clk); cal_req = 1'b0;
        ticks = 0; guard = 0;
        while (cal_busy && guard < 100) begin
            if (period_tick) ticks++;
            @(negedge clk); guard++;
        end
    endtask

    task automatic send_word(input logic [23:0] w);
        filt_data = w; filt_valid = 1'b1;
        @(negedge clk); filt_valid = 1'b0;
    endtask

    task automatic t_reset();
        check("R11 drdy_n", 32'(drdy_n), 32'd1);
        check("R11 busy/err/hold/frst", {28'd0, cal_busy, cal_err, mod_hold, filt_rst}, 32'd0);
        check("R11 ofs", 32'(ofs_reg), 32'd0);
        check("R11 fs", 32'(fs_reg), 32'd0);
        check("R11 dout", 32'(dout_word), 32'd0);
        check("R4 mirror", 32'(acr_rd), {24'd0, 1'b1, 7'h2A});
    endtask

    task automatic t_period();
        int guard = 0;
        int gap = 0;
        while (!period_tick && guard < 50) begin @(negedge clk); guard++; end
        @(negedge clk); gap = 1;
        while (!period_tick && gap < 50) begin @(negedge clk); gap++; end
        check("R1 tick spacing", 32'(gap), 32'(DP));
    endtask

    task automatic t_data();
        send_word(24'hA1B2C3);
        check("R2 drdy high first", 32'(drdy_n), 32'd1);
        check("R2 dout not yet", 32'(dout_word), 32'd0);
        @(negedge clk);
        check("R2 drdy low", 32'(drdy_n), 32'd0);
        check("R2 dout word", 32'(dout_word), 32'hA1B2C3);
        check("R4 mirror low", 32'(acr_rd[7]), 32'd0);
        rd_done = 1'b1; @(negedge clk); rd_done = 1'b0;
        check("R3 read raises drdy", 32'(drdy_n), 32'd1);
    endtask

    task automatic t_cal_both();
        int ticks;
        meas_ofs = 24'h111111; meas_fs = 24'h222222; gain_code = 3'd0;
        run_cal(3'd0, ticks);
        check("R5 two ticks", 32'(ticks), 32'd2);
        check("R5 drdy at end", 32'(drdy_n), 32'd0);
        check("R6 both ofs", 32'(ofs_reg), 32'h111111);
        check("R6 both fs", 32'(fs_reg), 32'h222222);
        send_word(24'hBADBAD); step(3);
        check("R9 first dropped", 32'(dout_word), 32'hA1B2C3);
        send_word(24'h0C0C0C); step(1);
        check("R9 second kept", 32'(dout_word), 32'h0C0C0C);
    endtask

    task automatic t_cal_kinds();
        int ticks;
        meas_ofs = 24'h333333; meas_fs = 24'h444444; gain_code = 3'd5;
        run_cal(3'd1, ticks);
        check("R6 self ofs loads ofs", 32'(ofs_reg), 32'h333333);
        check("R6 self ofs keeps fs", 32'(fs_reg), 32'h222222);
        gain_code = 3'd0;
        run_cal(3'd4, ticks);
        check("R6 sys gain loads fs", 32'(fs_reg), 32'h444444);
        check("R6 sys gain keeps ofs", 32'(ofs_reg), 32'h333333);
        meas_ofs = 24'h555555;
        cal_kind = 3'd6; cal_req = 1'b1; @(negedge clk); cal_req = 1'b0;
        check("R6 kind 6 ignored", 32'(cal_busy), 32'd0);
    endtask

    task automatic t_busy_ignore();
        meas_ofs = 24'h666666; meas_fs = 24'h777777;
        cal_kind = 3'd3; cal_req = 1'b1; @(negedge clk); cal_req = 1'b0;
        step(2);
        cal_kind = 3'd4; cal_req = 1'b1; @(negedge clk); cal_req = 1'b0;
        check("R8 still busy", 32'(cal_busy), 32'd1);
        send_word(24'hDEAD01); step(2);
        check("R9 busy drops word", 32'(dout_word), 32'h0C0C0C);
        while (cal_busy) @(negedge clk);
        check("R8 first kind kept ofs", 32'(ofs_reg), 32'h666666);
        check("R8 second kind ignored fs", 32'(fs_reg), 32'h444444);
    endtask

    task automatic t_gain_rule();
        int ticks;
        gain_code = 3'd3;
        cal_kind = 3'd2; cal_req = 1'b1; @(negedge clk); cal_req = 1'b0;
        check("R7 refused", 32'(cal_busy), 32'd0);
        check("R7 err set", 32'(cal_err), 32'd1);
        check("R7 fs untouched", 32'(fs_reg), 32'h444444);
        run_cal(3'd1, ticks);
        check("R7 offset any gain", 32'(ticks), 32'd2);
        check("R7 err sticky", 32'(cal_err), 32'd1);
    endtask

    task automatic t_sync();
        int n = 0;
        sync_req = 1'b1; @(negedge clk); sync_req = 1'b0;
        check("R10 filt_rst pulse", 32'(filt_rst), 32'd1);
        check("R10 hold set", 32'(mod_hold), 32'd1);
        @(negedge clk);
        check("R10 filt_rst ends", 32'(filt_rst), 32'd0);
        for (int i = 0; i < 3 * DP; i++) begin
            if (period_tick) n++;
            @(negedge clk);
        end
        check("R10 no tick in hold", 32'(n), 32'd0);
        sclk_edge = 1'b1; @(negedge clk); sclk_edge = 1'b0;
        check("R10 hold released", 32'(mod_hold), 32'd0);
        n = 1;
        while (!period_tick && n < 50) begin @(negedge clk); n++; end
        check("R10 restart distance", 32'(n), 32'(DP));
    endtask

    initial begin
        rst_n = 1'b0; cal_req = 0; filt_valid = 0; rd_done = 0; sync_req = 0;
        sclk_edge = 0; cal_kind = 0; gain_code = 0; meas_ofs = 0; meas_fs = 0;
        filt_data = 0; acr_cfg = 7'h2A;
        step(3);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_period();
        t_data();
        t_cal_both();
        t_cal_kinds();
        t_busy_ignore();
        t_gain_rule();
        t_sync();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule